// File: doc/BRIEF.md
# Return-from-exception sequencer

This block carries out a return-from-exception instruction for a 32-bit core. When `start` is pulsed it takes the instruction word, an encoding-class code, the base register value, the current mode field and the conditional-block position. It checks that the instruction is legal here. From the instruction bits it derives the direction and the optional extra-word offset, and it computes a start address.

It then reads two adjacent words through a request/valid memory port. The status word comes first and the program-counter word second. It presents the new program counter, the new status word and the base-register writeback together with a one-cycle `done` pulse. An illegal instruction or a memory error gives a one-cycle `abort` pulse instead, and the result outputs are left as they were.

The controller has five states:

- `S_IDLE` waits for `start`. It moves to `S_STAT` for a legal instruction and to `S_FAULT` for an illegal one.
- `S_STAT` holds a read request at start+4. On a valid response it moves to `S_PC`, or to `S_FAULT` if the response carries an error.
- `S_PC` holds a read request at the start address. On a valid response it moves to `S_FIN`, or to `S_FAULT` if the response carries an error.
- `S_FIN` drives `done` for one cycle and returns to `S_IDLE`.
- `S_FAULT` drives `abort` for one cycle and returns to `S_IDLE`.

Top module: `rfe_seq`

## Requirements
- R1: Decode match by `enc`. For `enc`=0 (classic), (insn & 0xFE500000) must equal 0xF8100000. For `enc`=1 (compact, decrementing), (insn & 0xFFD00000) must equal 0xE8100000. For `enc`=2 (compact, incrementing), the same mask must give 0xE9900000. A mismatch, or `enc`=3, aborts.
- R2: Direction and offset. For `enc`=0, the direction is increment when bit 23 is 1, and the extra +4 offset applies when bit 24 equals bit 23. For `enc`=1 the direction is always decrement with no offset. For `enc`=2 the direction is always increment with no offset.
- R3: The start address is the base when incrementing and base-8 when decrementing, plus 4 when the offset applies. The first read is at start+4 and the second read is at start.
- R4: `new_status` takes the word read at start+4 and `new_pc` takes the word read at start. Both are valid while `done` is high, and `done` is high for exactly one cycle.
- R5: `wb_idx` is instruction bits 19:16 and `wb_en` is bit 21. `wb_val` is base+8 when incrementing and base-8 when decrementing, whatever the offset.
- R6: A base index (bits 19:16) of 15 aborts the instruction without any memory read.
- R7: `mode` values 10001, 10010, 10011, 10110, 10111, 11011 and 11111 are privileged. The value 10000 and every other value abort the instruction without any memory read.
- R8: For `enc` 1 or 2, the instruction aborts when `it_inside`=1 and `it_last`=0. For `enc`=0 these two inputs have no effect.
- R9: An error response on either read aborts the instruction and `done` is not raised. An error on the first read means the second read is never requested.
- R10: `abort` is a one-cycle pulse and never coincides with `done`. On an abort, `new_pc`, `new_status`, `wb_en`, `wb_idx` and `wb_val` keep their previous values.
- R11: A request is held, with a stable address, until its valid response arrives. The next request is issued only after that response.
- R12: After reset, `done`, `abort`, `mem_req` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one instruction (sampled in `S_IDLE`) |
| insn | input | 32 | Instruction word |
| enc | input | 2 | Encoding class: 0 classic, 1 compact decrement, 2 compact increment |
| base | input | 32 | Base register value |
| mode | input | 5 | Current mode field of the status register |
| it_inside | input | 1 | Instruction lies inside a conditional block |
| it_last | input | 1 | Instruction is the last slot of that block |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Error flag qualifying `mem_rvalid` |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | One-cycle abort pulse |
| new_pc | output | 32 | New program counter |
| new_status | output | 32 | New status word |
| wb_en | output | 1 | Base writeback enable |
| wb_idx | output | 4 | Base register index |
| wb_val | output | 32 | Base writeback value |

## Verification
The assertions assume three things about the inputs. `mem_rvalid` arrives only while `mem_req` is high. A response is never given in the same cycle a request first appears. `start` is raised only while the block is idle.

The bench's memory model raises valid on the negative edge after it sees an unanswered request, and drops it one cycle later. The driver waits until the scoreboard has drained before it issues the next instruction, so `start` never lands on a busy sequencer.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    typedef enum logic [1:0] {
        ENC_CLASSIC = 2'd0,
        ENC_CMP_DEC = 2'd1,
        ENC_CMP_INC = 2'd2
    } enc_e;

    typedef struct packed {
        logic       fault;
        logic       inc;
        logic       extra;
        logic       wb;
        logic [3:0] idx;
    } dec_t;

    typedef enum logic [2:0] {
        S_IDLE, S_STAT, S_PC, S_FIN, S_FAULT
    } st_e;

    localparam logic [31:0] CLS_MASK = 32'hFE50_0000;
    localparam logic [31:0] CLS_VAL  = 32'hF810_0000;
    localparam logic [31:0] CMP_MASK = 32'hFFD0_0000;
    localparam logic [31:0] CMP_DVAL = 32'hE810_0000;
    localparam logic [31:0] CMP_IVAL = 32'hE990_0000;
endpackage

// File: rtl/rfe_decode.sv
module rfe_decode
    import rfe_pkg::*;
(
    input  logic [31:0] insn,
    input  logic [1:0]  enc,
    input  logic [4:0]  mode,
    input  logic        it_inside,
    input  logic        it_last,
    output dec_t        dec
);
    logic match;
    logic priv;
    logic slot_bad;

    always_comb begin
        case (mode)
            5'b10001, 5'b10010, 5'b10011, 5'b10110,
            5'b10111, 5'b11011, 5'b11111: priv = 1'b1;
            default:                      priv = 1'b0;
        endcase
    end

    always_comb begin
        match    = 1'b0;
        slot_bad = 1'b0;
        dec.inc   = 1'b0;
        dec.extra = 1'b0;
        case (enc)
            ENC_CLASSIC: begin
                match     = (insn & CLS_MASK) == CLS_VAL;
                dec.inc   = insn[23];
                dec.extra = insn[24] == insn[23];
            end
            ENC_CMP_DEC: begin
                match    = (insn & CMP_MASK) == CMP_DVAL;
                slot_bad = it_inside && !it_last;
            end
            ENC_CMP_INC: begin
                match    = (insn & CMP_MASK) == CMP_IVAL;
                dec.inc  = 1'b1;
                slot_bad = it_inside && !it_last;
            end
            default: match = 1'b0;
        endcase
        dec.idx   = insn[19:16];
        dec.wb    = insn[21];
        dec.fault = !match || (insn[19:16] == 4'hF) || !priv || slot_bad;
    end
endmodule

// File: rtl/rfe_agen.sv
module rfe_agen #(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  logic          inc,
    input  logic          extra,
    output logic [AW-1:0] stat_addr,
    output logic [AW-1:0] pc_addr,
    output logic [AW-1:0] wb_val
);
    localparam int PAIR_BYTES = 2 * WORD_BYTES;

    logic [AW-1:0] first;

    always_comb begin
        first     = inc ? base : base - AW'(PAIR_BYTES);
        pc_addr   = extra ? first + AW'(WORD_BYTES) : first;
        stat_addr = pc_addr + AW'(WORD_BYTES);
        wb_val    = inc ? base + AW'(PAIR_BYTES) : base - AW'(PAIR_BYTES);
    end
endmodule

// File: rtl/rfe_seq.sv
module rfe_seq
    import rfe_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   insn,
    input  logic [1:0]    enc,
    input  logic [AW-1:0] base,
    input  logic [4:0]    mode,
    input  logic          it_inside,
    input  logic          it_last,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          done,
    output logic          abort,
    output logic [DW-1:0] new_pc,
    output logic [DW-1:0] new_status,
    output logic          wb_en,
    output logic [3:0]    wb_idx,
    output logic [AW-1:0] wb_val
);
    st_e           state, nxt;
    dec_t          dec_now, dec_q;
    logic [AW-1:0] base_q;
    logic [DW-1:0] stat_q;
    logic [AW-1:0] stat_addr, pc_addr, wbv;

    rfe_decode u_dec (
        .insn      (insn),
        .enc       (enc),
        .mode      (mode),
        .it_inside (it_inside),
        .it_last   (it_last),
        .dec       (dec_now)
    );

    rfe_agen #(.AW(AW)) u_agen (
        .base      (base_q),
        .inc       (dec_q.inc),
        .extra     (dec_q.extra),
        .stat_addr (stat_addr),
        .pc_addr   (pc_addr),
        .wb_val    (wbv)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = dec_now.fault ? S_FAULT : S_STAT;
            S_STAT:  if (mem_rvalid) nxt = mem_err ? S_FAULT : S_PC;
            S_PC:    if (mem_rvalid) nxt = mem_err ? S_FAULT : S_FIN;
            S_FIN:   nxt = S_IDLE;
            S_FAULT: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q      <= '0;
            base_q     <= '0;
            stat_q     <= '0;
            new_pc     <= '0;
            new_status <= '0;
            wb_en      <= 1'b0;
            wb_idx     <= '0;
            wb_val     <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                dec_q  <= dec_now;
                base_q <= base;
            end
            if (state == S_STAT && mem_rvalid && !mem_err)
                stat_q <= mem_rdata;
            if (state == S_PC && mem_rvalid && !mem_err) begin
                new_pc     <= mem_rdata;
                new_status <= stat_q;
                wb_en      <= dec_q.wb;
                wb_idx     <= dec_q.idx;
                wb_val     <= wbv;
            end
        end
    end

    always_comb begin
        mem_req  = (state == S_STAT) || (state == S_PC);
        mem_addr = (state == S_STAT) ? stat_addr : pc_addr;
        done     = state == S_FIN;
        abort    = state == S_FAULT;
    end

    AST_DONE_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && abort));                                                   // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R4
    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_rvalid) && !$past(mem_err));               // R9
    AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> $stable(new_pc) && $stable(new_status) && $stable(wb_val)); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr));          // R11
    AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && dec_now.fault) |=> !mem_req);           // R6
endmodule

// File: tb/rfe_seq_test.sv
module rfe_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [1:0]  enc = '0;
    logic [31:0] base = '0;
    logic [4:0]  mode = 5'b10011;
    logic        it_inside = 1'b0, it_last = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        done, abort, wb_en;
    logic [31:0] new_pc, new_status, wb_val;
    logic [3:0]  wb_idx;

    int checks = 0, failures = 0, pending = 0;
    bit err_on = 0;
    logic [31:0] err_addr = '0;
    logic [31:0] last_pc = '0, last_st = '0;

    typedef struct {
        bit          is_abort;
        logic [31:0] pc, st, wbv;
        bit          wbe;
        logic [3:0]  idx;
        string       tag;
    } exp_t;
    exp_t        exp_q[$];
    logic [31:0] addr_q[$];

    always #2.5 clk = ~clk;

    rfe_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .enc(enc),
        .base(base), .mode(mode), .it_inside(it_inside), .it_last(it_last),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .done(done), .abort(abort),
        .new_pc(new_pc), .new_status(new_status), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_val(wb_val)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // memory model
    initial forever begin
        @(negedge clk);
        if (mem_req && !mem_rvalid) begin
            logic [31:0] e;
            e = (addr_q.size() > 0) ? addr_q.pop_front() : 32'hDEAD_BEEF;
            chk(mem_addr == e, "R3/R11 read address order", mem_addr, e);
            mem_rvalid = 1'b1;
            mem_rdata  = memf(mem_addr);
            mem_err    = err_on && (mem_addr == err_addr);
        end else begin
            mem_rvalid = 1'b0;
            mem_err    = 1'b0;
        end
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (rst_n && (done || abort)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected result pulse", {30'd0, done, abort}, 32'd0);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                chk(abort == x.is_abort, {x.tag, " kind"}, {31'd0, abort}, {31'd0, x.is_abort});
                if (x.is_abort) begin
                    chk(new_pc == last_pc, {x.tag, " R10 pc kept"}, new_pc, last_pc);
                    chk(new_status == last_st, {x.tag, " R10 status kept"}, new_status, last_st);
                end else begin
                    chk(new_pc == x.pc, {x.tag, " R4 pc"}, new_pc, x.pc);
                    chk(new_status == x.st, {x.tag, " R4 status"}, new_status, x.st);
                    chk(wb_en == x.wbe, {x.tag, " R5 wb_en"}, {31'd0, wb_en}, {31'd0, x.wbe});
                    chk(wb_idx == x.idx, {x.tag, " R5 wb_idx"}, {28'd0, wb_idx}, {28'd0, x.idx});
                    chk(wb_val == x.wbv, {x.tag, " R5 wb_val"}, wb_val, x.wbv);
                    last_pc = x.pc;
                    last_st = x.st;
                end
                @(negedge clk);
                chk(!done && !abort, {x.tag, " R4/R10 single-cycle pulse"}, {30'd0, done, abort}, 32'd0);
                pending--;
            end
        end
    end

    task automatic run(input string tag, input logic [31:0] in, input logic [1:0] en,
                       input logic [31:0] b, input logic [4:0] md, input bit ins,
                       input bit lst, input int errsel);
        exp_t  x;
        bit    match, priv, inc, extra, fault;
        logic [31:0] st;
        match = 0; inc = 0; extra = 0;
        case (en)
            2'd0: begin match = (in & 32'hFE50_0000) == 32'hF810_0000;
                        inc = in[23]; extra = (in[24] == in[23]); end
            2'd1: match = ((in & 32'hFFD0_0000) == 32'hE810_0000) && !(ins && !lst);
            2'd2: begin match = ((in & 32'hFFD0_0000) == 32'hE990_0000) && !(ins && !lst);
                        inc = 1; end
            default: match = 0;
        endcase
        priv = md inside {5'b10001, 5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11011, 5'b11111};
        fault = !match || !priv || (in[19:16] == 4'hF);
        st = (inc ? b : b - 32'd8) + (extra ? 32'd4 : 32'd0);
        x.tag = tag; x.pc = memf(st); x.st = memf(st + 32'd4);
        x.wbe = in[21]; x.idx = in[19:16]; x.wbv = inc ? b + 32'd8 : b - 32'd8;
        x.is_abort = fault || errsel != 0;
        err_on = errsel != 0;
        err_addr = (errsel == 1) ? st + 32'd4 : st;
        if (!fault) begin
            addr_q.push_back(st + 32'd4);
            if (errsel != 1) addr_q.push_back(st);
        end
        exp_q.push_back(x);
        pending++;
        @(negedge clk);
        insn = in; enc = en; base = b; mode = md; it_inside = ins; it_last = lst;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (pending != 0) @(negedge clk);
        chk(addr_q.size() == 0, {tag, " R9/R6 reads issued"}, addr_q.size(), 0);
        addr_q.delete();
    endtask

    function automatic logic [31:0] cls(input bit p, input bit u, input bit w, input logic [3:0] n);
        return 32'hF810_0A00 | (32'(p) << 24) | (32'(u) << 23) | (32'(w) << 21) | (32'(n) << 16);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !abort && !mem_req, "R12 reset controls", {29'd0, done, abort, mem_req}, 0);
        chk(new_pc == 0 && new_status == 0 && wb_val == 0 && !wb_en, "R12 reset results", new_pc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !done, "R12 idle after reset", {31'd0, mem_req}, 0);

        run("R2/R3 classic IA",   cls(0, 1, 1, 4'd2), 2'd0, 32'h0000_1000, 5'b10011, 0, 0, 0);
        run("R2/R3 classic IB",   cls(1, 1, 0, 4'd3), 2'd0, 32'h0000_2000, 5'b10010, 0, 0, 0);
        run("R2/R3 classic DA",   cls(0, 0, 1, 4'd4), 2'd0, 32'h0000_3000, 5'b11111, 0, 0, 0);
        run("R2/R3 classic DB",   cls(1, 0, 1, 4'd5), 2'd0, 32'h0000_4000, 5'b10001, 0, 0, 0);
        run("R2 compact dec",     32'hE830_0000 | (32'd6 << 16), 2'd1, 32'h0000_5000, 5'b10110, 0, 0, 0);
        run("R2 compact inc",     32'hE990_0000 | (32'd7 << 16), 2'd2, 32'h0000_6000, 5'b11011, 1, 1, 0);
        run("R5 dec wrap",        cls(1, 0, 1, 4'd0), 2'd0, 32'h0000_0004, 5'b10111, 0, 0, 0);
        run("R6 base index 15",   cls(0, 1, 1, 4'hF), 2'd0, 32'h0000_7000, 5'b10011, 0, 0, 0);
        run("R7 user mode",       cls(0, 1, 1, 4'd1), 2'd0, 32'h0000_7000, 5'b10000, 0, 0, 0);
        run("R7 invalid mode",    cls(0, 1, 1, 4'd1), 2'd0, 32'h0000_7000, 5'b00000, 0, 0, 0);
        run("R8 compact mid-block", 32'hE990_0000 | (32'd1 << 16), 2'd2, 32'h0000_7100, 5'b10011, 1, 0, 0);
        run("R8 classic mid-block ignored", cls(0, 1, 0, 4'd8), 2'd0, 32'h0000_7200, 5'b10011, 1, 0, 0);
        run("R1 classic mismatch", 32'h0000_0000, 2'd0, 32'h0000_7300, 5'b10011, 0, 0, 0);
        run("R1 compact wrong form", 32'hE990_0000 | (32'd1 << 16), 2'd1, 32'h0000_7300, 5'b10011, 0, 0, 0);
        run("R1 enc 3",           cls(0, 1, 1, 4'd1), 2'd3, 32'h0000_7300, 5'b10011, 0, 0, 0);
        run("R9 err on status",   cls(0, 1, 1, 4'd9), 2'd0, 32'h0000_8000, 5'b10011, 0, 0, 1);
        run("R9 err on pc",       cls(1, 0, 1, 4'd9), 2'd0, 32'h0000_9000, 5'b10011, 0, 0, 2);
        run("R4 after errors",    cls(1, 1, 1, 4'd10), 2'd0, 32'h0000_A000, 5'b10011, 0, 0, 0);
        finish_run();
    end
endmodule